// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the control state for one bus-master DMA channel. It has three registers: a command register, a status register and a descriptor-table base register. A single-cycle register port writes and reads them. The block turns edges of the command's run bit into one-cycle start and cancel pulses for the descriptor walker. On each start it reloads the walker's table pointer from the base register. It also tracks whether the channel is busy.

A drive interrupt line passes through to the host interrupt without delay. A rising edge on that line also latches an interrupt flag in status, and software clears the flag by writing a 1 to it. The transfer engine reports when it goes idle and whether more work is queued. That report updates the busy bit.

The register port carries no streamed data, so it has no valid/ready handshake and never applies back-pressure. A write asserted with `reg_wr` for one cycle always lands at the next clock edge. Reads are combinational from `reg_sel`, `reg_off` and `reg_size`. Selector codes: 0 command, 1 status, 2 base, 3 unused (reads zero).

Top module: `bmctl_regs`

## Requirements
- R1: A command write whose bit 0 (run) equals the stored run bit produces no start or cancel pulse, leaves the table pointer and the busy bit unchanged, and still updates bit 3.
- R2: A command write that changes run from 1 to 0 raises `cancel_pulse` for exactly one cycle after the write edge and clears status bit 0 (busy).
- R3: A command write that changes run from 0 to 1 loads `tbl_ptr` from the base register. If busy was clear, it sets busy and raises `start_pulse` for one cycle; if busy was already set, it gives no start pulse.
- R4: The command register keeps only write bits 0 and 3; every other command bit reads as zero.
- R5: Base writes of 1, 2 or 4 bytes (`reg_size` 0, 1, 2) at byte offset `reg_off` replace only the addressed byte lanes, taking data from the low bytes of `reg_wdata`. Base bits [1:0] always read zero.
- R6: A base read returns the base register shifted down by 8×`reg_off` and masked to the access width.
- R7: `host_irq` equals `drv_irq` in the same cycle. A rising edge of `drv_irq` sets status bit 2; a steady high or low level does not set it.
- R8: Writing 1 to status bit 2 clears it, and writing 0 leaves it. Status bits 5 and 6 are plain read/write flags. A status write never changes busy, and status bits 1, 3, 4 and 7 read zero.
- R9: When `eng_idle` is high, busy becomes `eng_more` at the next edge.
- R10: After reset, the command, status and base registers read zero, `tbl_ptr` is zero and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 command, 1 status, 2 base |
| reg_off | input | 2 | Byte offset within the base register |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Write data (command/status use bits 7:0) |
| reg_rdata | output | 32 | Combinational read data |
| drv_irq | input | 1 | Drive interrupt level |
| host_irq | output | 1 | Host interrupt level |
| eng_idle | input | 1 | Transfer engine went inactive this cycle |
| eng_more | input | 1 | With `eng_idle`: more work remains |
| start_pulse | output | 1 | One-cycle start request to the walker |
| cancel_pulse | output | 1 | One-cycle cancel request to the walker |
| tbl_ptr | output | 32 | Current descriptor-table pointer |

## Verification
A stored run bit that is out of step with software would show on the very next write. The write would either give a pulse when run was rewritten with the same value, or give none on a real change, and both pulse pins are visible one cycle after the write edge. A wrong busy bit shows in the next status read and in whether a 0-to-1 run change starts the walker. A bad lane mask in the base register shows at once on readback through the shifted read path. Edge detection on the drive interrupt is probed by holding the line high across a clear, which must not set the flag again.

// File: rtl/bmctl_pkg.sv
package bmctl_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_RUN_BIT  = 0;
  localparam int CMD_DIR_BIT  = 3;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_IRQ     = 2;
  localparam int STAT_FLAG_LO = 5;
  localparam int STAT_FLAG_HI = 6;
endpackage

// File: rtl/bmctl_base.sv
module bmctl_base #(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int OW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] rdata
);
  logic [LANES-1:0] width_lanes;
  logic [LANES-1:0] wmask;
  logic [DW-1:0]    shifted;
  logic [DW-1:0]    rmask;
  int               nbytes;

  always_comb begin
    nbytes = 1 << size;
    if (nbytes > LANES) nbytes = LANES;
    for (int i = 0; i < LANES; i++) begin
      width_lanes[i]  = (i < nbytes);
      rmask[i*8 +: 8] = {8{width_lanes[i]}};
    end
    wmask   = width_lanes << off;
    shifted = wdata << {off, 3'b000};
    rdata   = (base_q >> {off, 3'b000}) & rmask;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (!rst_n) base_q[7:0] <= '0;
        else if (wr && wmask[0]) base_q[7:0] <= {shifted[7:2], 2'b00};
      end
    end else begin : g_up
      always_ff @(posedge clk) begin
        if (!rst_n) base_q[g*8 +: 8] <= '0;
        else if (wr && wmask[g]) base_q[g*8 +: 8] <= shifted[g*8 +: 8];
      end
    end
  end

  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00); // R5
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(base_q)); // R5
endmodule

// File: rtl/bmctl_cmd.sv
module bmctl_cmd #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [7:0]    wbyte,
  input  logic [DW-1:0] base,
  input  logic          eng_idle,
  input  logic          eng_more,
  output logic          run_q,
  output logic          dir_q,
  output logic          busy_q,
  output logic          start_pulse,
  output logic          cancel_pulse,
  output logic [DW-1:0] tbl_ptr
);
  import bmctl_pkg::*;

  logic run_new;
  assign run_new = wbyte[CMD_RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      dir_q        <= 1'b0;
      busy_q       <= 1'b0;
      start_pulse  <= 1'b0;
      cancel_pulse <= 1'b0;
      tbl_ptr      <= '0;
    end else begin
      start_pulse  <= 1'b0;
      cancel_pulse <= 1'b0;
      if (eng_idle) busy_q <= eng_more;
      if (wr_cmd) begin
        if (run_new != run_q) begin
          if (!run_new) begin
            cancel_pulse <= 1'b1;
            busy_q       <= 1'b0;
          end else begin
            tbl_ptr <= base;
            if (!busy_q) begin
              busy_q      <= 1'b1;
              start_pulse <= 1'b1;
            end
          end
        end
        run_q <= run_new;
        dir_q <= wbyte[CMD_DIR_BIT];
      end
    end
  end

  AST_SAME_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && run_new == run_q) |=> (!start_pulse && !cancel_pulse && $stable(tbl_ptr))); // R1
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pulse |-> (!busy_q && !run_q)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (busy_q && run_q)); // R3
  AST_PTR_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(tbl_ptr)); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && cancel_pulse)); // R2
endmodule

// File: rtl/bmctl_irq.sv
module bmctl_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_irq,
  input  logic       wr_stat,
  input  logic [7:0] wbyte,
  output logic       irq_q,
  output logic [1:0] flags_q,
  output logic       host_irq
);
  import bmctl_pkg::*;

  logic drv_d;
  logic rise;

  assign host_irq = drv_irq;
  assign rise     = drv_irq && !drv_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_d   <= 1'b0;
      irq_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      drv_d <= drv_irq;
      if (rise) irq_q <= 1'b1;
      else if (wr_stat && wbyte[STAT_IRQ]) irq_q <= 1'b0;
      if (wr_stat) flags_q <= wbyte[STAT_FLAG_HI:STAT_FLAG_LO];
    end
  end

  AST_IRQ_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> irq_q); // R7
  AST_IRQ_LEVEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_irq && !wr_stat) |=> $stable(irq_q)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(flags_q)); // R8
endmodule

// File: rtl/bmctl_regs.sv
module bmctl_regs #(
  parameter int DW = 32,
  localparam int OW = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [OW-1:0] reg_off,
  input  logic [1:0]    reg_size,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          drv_irq,
  output logic          host_irq,
  input  logic          eng_idle,
  input  logic          eng_more,
  output logic          start_pulse,
  output logic          cancel_pulse,
  output logic [DW-1:0] tbl_ptr
);
  import bmctl_pkg::*;

  reg_sel_e      sel;
  logic          wr_cmd, wr_stat, wr_base;
  logic [DW-1:0] base_q, base_rd;
  logic          run_q, dir_q, busy_q, irq_q;
  logic [1:0]    flags_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_cmd  = reg_wr && (sel == SEL_CMD);
  assign wr_stat = reg_wr && (sel == SEL_STAT);
  assign wr_base = reg_wr && (sel == SEL_BASE);

  bmctl_base #(.DW(DW)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(wr_base), .off(reg_off), .size(reg_size),
    .wdata(reg_wdata), .base_q(base_q), .rdata(base_rd)
  );

  bmctl_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wbyte(reg_wdata[7:0]),
    .base(base_q), .eng_idle(eng_idle), .eng_more(eng_more),
    .run_q(run_q), .dir_q(dir_q), .busy_q(busy_q),
    .start_pulse(start_pulse), .cancel_pulse(cancel_pulse), .tbl_ptr(tbl_ptr)
  );

  bmctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .wr_stat(wr_stat),
    .wbyte(reg_wdata[7:0]), .irq_q(irq_q), .flags_q(flags_q), .host_irq(host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CMD: begin
        reg_rdata[CMD_RUN_BIT] = run_q;
        reg_rdata[CMD_DIR_BIT] = dir_q;
      end
      SEL_STAT: begin
        reg_rdata[STAT_BUSY]                  = busy_q;
        reg_rdata[STAT_IRQ]                   = irq_q;
        reg_rdata[STAT_FLAG_HI:STAT_FLAG_LO]  = flags_q;
      end
      SEL_BASE: reg_rdata = base_rd;
      default:  reg_rdata = '0;
    endcase
  end

  AST_STAT_WR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !eng_idle) |=> $stable(busy_q)); // R8
  AST_IDLE_TRACKS_MORE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !wr_cmd) |=> (busy_q == $past(eng_more))); // R9
endmodule

// File: tb/tb_bmctl_regs.sv
module tb_bmctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [1:0]  reg_off = 2'd0;
  logic [1:0]  reg_size = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        drv_irq = 1'b0;
  logic        host_irq;
  logic        eng_idle = 1'b0;
  logic        eng_more = 1'b0;
  logic        start_pulse, cancel_pulse;
  logic [31:0] tbl_ptr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bmctl_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .drv_irq(drv_irq), .host_irq(host_irq),
    .eng_idle(eng_idle), .eng_more(eng_more), .start_pulse(start_pulse),
    .cancel_pulse(cancel_pulse), .tbl_ptr(tbl_ptr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // write lands at the posedge; returns at the following negedge
  task automatic wr(logic [1:0] s, logic [1:0] o, logic [1:0] z, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_off = o; reg_size = z; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, logic [1:0] o, logic [1:0] z, output logic [31:0] d);
    reg_sel = s; reg_off = o; reg_size = z;
    #1 d = reg_rdata;
  endtask

  task automatic eng(logic more);
    @(negedge clk);
    eng_idle = 1'b1; eng_more = more;
    @(negedge clk);
    eng_idle = 1'b0; eng_more = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 0, 0, d); chk("R10 cmd", d, 0);
    rd(1, 0, 0, d); chk("R10 status", d, 0);
    rd(2, 0, 2, d); chk("R10 base", d, 0);
    chk("R10 ptr", tbl_ptr, 0);
    chk("R10 pulses", {start_pulse, cancel_pulse}, 0);
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(2, 0, 2, 32'h1234_5677);
    rd(2, 0, 2, d); chk("R5 word, low bits zero", d, 32'h1234_5674);
    wr(2, 2, 0, 32'h0000_00AB);
    rd(2, 0, 2, d); chk("R5 byte lane 2", d, 32'h12AB_5674);
    wr(2, 0, 1, 32'h0000_BEEF);
    rd(2, 0, 2, d); chk("R5 half lanes 0-1", d, 32'h12AB_BEEC);
    rd(2, 1, 0, d); chk("R6 byte read off1", d, 32'h0000_00BE);
    rd(2, 2, 1, d); chk("R6 half read off2", d, 32'h0000_12AB);
    rd(2, 3, 0, d); chk("R6 byte read off3", d, 32'h0000_0012);
  endtask

  task automatic t_cmd_bits();
    logic [31:0] d;
    wr(0, 0, 0, 32'h0000_00FE);
    chk("R1 no pulse on same run 0", {start_pulse, cancel_pulse}, 0);
    rd(0, 0, 0, d); chk("R4 only bit3 kept", d, 32'h08);
  endtask

  task automatic t_start();
    logic [31:0] d;
    wr(0, 0, 0, 32'h01);
    chk("R3 start pulse", start_pulse, 1);
    chk("R3 ptr loaded", tbl_ptr, 32'h12AB_BEEC);
    rd(1, 0, 0, d); chk("R3 busy set", d, 32'h01);
    rd(0, 0, 0, d); chk("R4 cmd read", d, 32'h01);
    @(negedge clk);
    chk("R3 pulse one cycle", start_pulse, 0);
  endtask

  task automatic t_same_run();
    logic [31:0] d;
    wr(2, 0, 2, 32'h0000_0100);
    wr(0, 0, 0, 32'h09);
    chk("R1 no pulse same run 1", {start_pulse, cancel_pulse}, 0);
    chk("R1 ptr kept", tbl_ptr, 32'h12AB_BEEC);
    rd(0, 0, 0, d); chk("R1 bit3 updated", d, 32'h09);
    rd(1, 0, 0, d); chk("R1 busy kept", d, 32'h01);
  endtask

  task automatic t_engine();
    logic [31:0] d;
    eng(1'b1);
    rd(1, 0, 0, d); chk("R9 more keeps busy", d, 32'h01);
    eng(1'b0);
    rd(1, 0, 0, d); chk("R9 done clears busy", d, 32'h00);
    eng(1'b1);
    rd(1, 0, 0, d); chk("R9 more sets busy", d, 32'h01);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    wr(0, 0, 0, 32'h00);
    chk("R2 cancel pulse", cancel_pulse, 1);
    chk("R2 no start", start_pulse, 0);
    rd(1, 0, 0, d); chk("R2 busy cleared", d, 32'h00);
    @(negedge clk);
    chk("R2 pulse one cycle", cancel_pulse, 0);
  endtask

  task automatic t_start_when_busy();
    logic [31:0] d;
    eng(1'b1);
    wr(0, 0, 0, 32'h01);
    chk("R3 no start while busy", start_pulse, 0);
    chk("R3 ptr reloaded", tbl_ptr, 32'h0000_0100);
    rd(1, 0, 0, d); chk("R3 busy stays", d, 32'h01);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    @(negedge clk); drv_irq = 1'b1;
    #1 chk("R7 host follows high", host_irq, 1);
    @(negedge clk);
    rd(1, 0, 0, d); chk("R7 rise sets irq", d, 32'h05);
    wr(1, 0, 0, 32'h60);
    rd(1, 0, 0, d); chk("R8 write0 keeps irq, flags set", d, 32'h65);
    wr(1, 0, 0, 32'h04);
    rd(1, 0, 0, d); chk("R7 level high no reset", d, 32'h01);
    @(negedge clk); drv_irq = 1'b0;
    #1 chk("R7 host follows low", host_irq, 0);
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); drv_irq = 1'b0;
    @(negedge clk);
    rd(1, 0, 0, d); chk("R7 pulse edge sets irq", d, 32'h05);
    wr(1, 0, 0, 32'h25);
    rd(1, 0, 0, d); chk("R8 clear irq, busy untouched", d, 32'h21);
    wr(1, 0, 0, 32'hFE);
    rd(1, 0, 0, d); chk("R8 reserved zero, busy kept", d, 32'h61);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_cmd_bits();
    t_start();
    t_same_run();
    t_engine();
    t_cancel();
    t_start_when_busy();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule